// File: doc/BRIEF.md
# Register Writer Scoreboard

This block records, for every architectural register of an in-order pipeline, which instructions still have to write that register. The registers fall into three classes: integer, floating point and miscellaneous. Each register has a short queue that holds the sequence numbers of its pending writers in program order. The issue stage adds a writer when an instruction with a destination enters the pipeline. Writeback takes writers out again, either from the head of the queue or from any position, for example when an instruction is squashed.

Three combinational query ports answer questions about the current contents. The read query says whether an instruction may read a register from the register file. The write query applies the same rule through a separate port. The forward query names the nearest older pending writer as a forwarding candidate. It then marks the candidate as usable once the caller reports that this writer has executed and that its result-ready cycle lies before the current cycle. Misuse of the queues is flagged on three error outputs in the same cycle as the request.

Top module: `regdep_scoreboard`

## Requirements
- R1: The class code selects the queue group: 0 is integer, 1 is floating point, 2 is miscellaneous. Registers with the same index in different classes are tracked separately. Class code 3 names no register: inserts and removals with it are ignored and raise no error, read and write queries on it answer 1, and a forward query on it reports no candidate.
- R2: An insert appends the sequence number at the tail of the selected queue, so the head always holds the oldest pending writer.
- R3: Integer register 0 is never tracked. Inserts and removals addressed to it change nothing and raise no error, so queries on it always find an empty queue.
- R4: `rd_ok` is 1 when the selected queue is empty, or when `rd_seq` is less than or equal to the head entry. Otherwise it is 0.
- R5: `wr_ok` follows the rule of R4, using the write query port's own inputs.
- R6: Starting at the head, the forward query walks the queue while entries are strictly less than `fw_seq`. `fw_cand_vld` is 1 when at least one entry qualifies, and `fw_cand_seq` is then the last qualifying entry.
- R7: `fw_hit` is 1 only when a candidate exists, `fw_exec` is 1, and `fw_ready_cyc` is strictly less than `fw_now`.
- R8: Arbitrary removal deletes the first entry equal to `rma_seq` and closes the gap while keeping the order of the rest. If no entry matches, `err_rma_miss` is 1 in that cycle and the queue is unchanged.
- R9: Head removal pops the head when it equals `rmh_seq`. If the queue is empty or the head differs, `err_rmh_bad` is 1 in that cycle and the queue is unchanged.
- R10: Each queue holds DEPTH entries (4 by default). An insert into a full queue sets `err_ovf` in that cycle and is dropped.
- R11: When several ports address the same queue in one cycle, they are applied in this order: head removal, then arbitrary removal, then insert. Whether the queue is full is judged after the removals. All queries and error outputs reflect the state before the clock edge that applies the update.
- R12: A synchronous active-high `rst` empties every queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_vld | input | 1 | Insert request |
| ins_cls | input | 2 | Insert register class |
| ins_idx | input | IDX_W | Insert register index |
| ins_seq | input | SEQ_W | Sequence number to append |
| rma_vld | input | 1 | Arbitrary-removal request |
| rma_cls | input | 2 | Arbitrary-removal class |
| rma_idx | input | IDX_W | Arbitrary-removal index |
| rma_seq | input | SEQ_W | Sequence number to delete |
| rmh_vld | input | 1 | Head-removal request |
| rmh_cls | input | 2 | Head-removal class |
| rmh_idx | input | IDX_W | Head-removal index |
| rmh_seq | input | SEQ_W | Expected head sequence number |
| rd_cls | input | 2 | Read query class |
| rd_idx | input | IDX_W | Read query index |
| rd_seq | input | SEQ_W | Read query requester |
| rd_ok | output | 1 | Register may be read |
| wr_cls | input | 2 | Write query class |
| wr_idx | input | IDX_W | Write query index |
| wr_seq | input | SEQ_W | Write query requester |
| wr_ok | output | 1 | Register may be written |
| fw_cls | input | 2 | Forward query class |
| fw_idx | input | IDX_W | Forward query index |
| fw_seq | input | SEQ_W | Forward query requester |
| fw_cand_vld | output | 1 | A forwarding candidate exists |
| fw_cand_seq | output | SEQ_W | Candidate sequence number |
| fw_exec | input | 1 | Candidate has executed |
| fw_ready_cyc | input | CYC_W | Candidate result-ready cycle |
| fw_now | input | CYC_W | Current cycle |
| fw_hit | output | 1 | Candidate can supply the value |
| err_ovf | output | 1 | Insert into a full queue |
| err_rma_miss | output | 1 | Arbitrary removal found no match |
| err_rmh_bad | output | 1 | Head removal on an empty queue or wrong head |

## Verification
Query answers and error flags are combinational, so each one is due in the same cycle its inputs are applied, and it describes the queue state held before the next edge. The effect of an insert or removal appears only from the cycle after that edge. The bench changes inputs at the falling edge and samples one time unit later, before the rising edge. It applies its model update only after comparing that cycle's answers, so every check sees the pre-update state that R11 requires.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_MISC = 2'd2,
        CLS_NONE = 2'd3
    } reg_cls_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/sb_writer_q.sv
// One register's pending-writer queue. Same-cycle order:
// head pop, then arbitrary delete, then append.
module sb_writer_q #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ins_hit,
    input  logic [SEQ_W-1:0]            ins_seq,
    input  logic                        rma_hit,
    input  logic [SEQ_W-1:0]            rma_seq,
    input  logic                        rmh_hit,
    input  logic [SEQ_W-1:0]            rmh_seq,
    output logic [DEPTH-1:0][SEQ_W-1:0] ent,
    output logic [CNT_W-1:0]            cnt,
    output logic                        ovf,
    output logic                        rma_miss,
    output logic                        rmh_bad
);
    logic [DEPTH-1:0][SEQ_W-1:0] ent_q, s1, s2, s3;
    logic [CNT_W-1:0]            cnt_q, c1, c2, c3;
    logic [DEPTH-1:0]            match, past;
    logic                        found;

    always_comb begin
        // stage 1: head removal
        s1      = ent_q;
        c1      = cnt_q;
        rmh_bad = 1'b0;
        if (rmh_hit) begin
            if (c1 == '0 || s1[0] != rmh_seq) begin
                rmh_bad = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) s1[i] = ent_q[i+1];
                c1 = cnt_q - 1'b1;
            end
        end
        // stage 2: arbitrary removal with compaction
        s2       = s1;
        c2       = c1;
        rma_miss = 1'b0;
        found    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = (CNT_W'(i) < c1) && (s1[i] == rma_seq);
            if (match[i]) found = 1'b1;
            past[i] = found;
        end
        if (rma_hit) begin
            if (found) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (past[i]) s2[i] = s1[i+1];
                end
                c2 = c1 - 1'b1;
            end else begin
                rma_miss = 1'b1;
            end
        end
        // stage 3: append
        s3  = s2;
        c3  = c2;
        ovf = 1'b0;
        if (ins_hit) begin
            if (c2 == CNT_W'(DEPTH)) begin
                ovf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == c2) s3[i] = ins_seq;
                end
                c3 = c2 + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= s3;
            cnt_q <= c3;
        end
    end

    assign ent = ent_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/sb_clear_chk.sv
// Read/write permission: empty queue or requester not younger than head.
module sb_clear_chk #(
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3
) (
    input  logic [SEQ_W-1:0] head,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEQ_W-1:0] req_seq,
    output logic             clear
);
    assign clear = (cnt == '0) || (req_seq <= head);
endmodule

// File: rtl/sb_fwd_pick.sv
// Youngest writer that is still older than the requester.
module sb_fwd_pick #(
    parameter int DEPTH = 4,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3
) (
    input  logic [DEPTH-1:0][SEQ_W-1:0] ent,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [SEQ_W-1:0]            req_seq,
    output logic                        cand_vld,
    output logic [SEQ_W-1:0]            cand_seq
);
    logic stop;

    always_comb begin
        cand_vld = 1'b0;
        cand_seq = '0;
        stop     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && CNT_W'(i) < cnt && ent[i] < req_seq) begin
                cand_vld = 1'b1;
                cand_seq = ent[i];
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regdep_scoreboard.sv
module regdep_scoreboard
    import sb_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int DEPTH = 4,
    parameter int SEQ_W = 16,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_vld,
    input  logic [1:0]       ins_cls,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             rma_vld,
    input  logic [1:0]       rma_cls,
    input  logic [IDX_W-1:0] rma_idx,
    input  logic [SEQ_W-1:0] rma_seq,
    input  logic             rmh_vld,
    input  logic [1:0]       rmh_cls,
    input  logic [IDX_W-1:0] rmh_idx,
    input  logic [SEQ_W-1:0] rmh_seq,
    input  logic [1:0]       rd_cls,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [SEQ_W-1:0] rd_seq,
    output logic             rd_ok,
    input  logic [1:0]       wr_cls,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_seq,
    output logic             wr_ok,
    input  logic [1:0]       fw_cls,
    input  logic [IDX_W-1:0] fw_idx,
    input  logic [SEQ_W-1:0] fw_seq,
    output logic             fw_cand_vld,
    output logic [SEQ_W-1:0] fw_cand_seq,
    input  logic             fw_exec,
    input  logic [CYC_W-1:0] fw_ready_cyc,
    input  logic [CYC_W-1:0] fw_now,
    output logic             fw_hit,
    output logic             err_ovf,
    output logic             err_rma_miss,
    output logic             err_rmh_bad
);
    localparam int NREG  = 1 << IDX_W;
    localparam int NQ    = NUM_CLS * NREG;
    localparam int QW    = $clog2(NQ);
    localparam int CNT_W = $clog2(DEPTH + 1);

    function automatic logic tracked(input logic [1:0] cls, input logic [IDX_W-1:0] idx);
        return reg_cls_e'(cls) != CLS_NONE && !(reg_cls_e'(cls) == CLS_INT && idx == '0);
    endfunction

    function automatic logic [QW-1:0] flat_of(input logic [1:0] cls, input logic [IDX_W-1:0] idx);
        if (reg_cls_e'(cls) == CLS_NONE) return '0;
        return QW'(int'(cls) * NREG + int'(idx));
    endfunction

    logic [DEPTH-1:0][SEQ_W-1:0] q_ent [NQ];
    logic [CNT_W-1:0]            q_cnt [NQ];
    logic [NQ-1:0]               ovf_v, miss_v, bad_v;

    logic [QW-1:0] ins_f, rma_f, rmh_f, rd_f, wr_f, fw_f;
    logic          ins_t, rma_t, rmh_t;

    assign ins_f = flat_of(ins_cls, ins_idx);
    assign rma_f = flat_of(rma_cls, rma_idx);
    assign rmh_f = flat_of(rmh_cls, rmh_idx);
    assign rd_f  = flat_of(rd_cls, rd_idx);
    assign wr_f  = flat_of(wr_cls, wr_idx);
    assign fw_f  = flat_of(fw_cls, fw_idx);
    assign ins_t = ins_vld && tracked(ins_cls, ins_idx);
    assign rma_t = rma_vld && tracked(rma_cls, rma_idx);
    assign rmh_t = rmh_vld && tracked(rmh_cls, rmh_idx);

    for (genvar g = 0; g < NQ; g++) begin : g_q
        sb_writer_q #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_q (
            .clk      (clk),
            .rst      (rst),
            .ins_hit  (ins_t && ins_f == QW'(g)),
            .ins_seq  (ins_seq),
            .rma_hit  (rma_t && rma_f == QW'(g)),
            .rma_seq  (rma_seq),
            .rmh_hit  (rmh_t && rmh_f == QW'(g)),
            .rmh_seq  (rmh_seq),
            .ent      (q_ent[g]),
            .cnt      (q_cnt[g]),
            .ovf      (ovf_v[g]),
            .rma_miss (miss_v[g]),
            .rmh_bad  (bad_v[g])
        );
    end

    assign err_ovf      = |ovf_v;
    assign err_rma_miss = |miss_v;
    assign err_rmh_bad  = |bad_v;

    // query-side selection; class 3 sees an empty queue
    logic [CNT_W-1:0] rd_cnt, wr_cnt, fw_cnt;
    assign rd_cnt = (reg_cls_e'(rd_cls) == CLS_NONE) ? '0 : q_cnt[rd_f];
    assign wr_cnt = (reg_cls_e'(wr_cls) == CLS_NONE) ? '0 : q_cnt[wr_f];
    assign fw_cnt = (reg_cls_e'(fw_cls) == CLS_NONE) ? '0 : q_cnt[fw_f];

    sb_clear_chk #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_rd (
        .head (q_ent[rd_f][0]), .cnt (rd_cnt), .req_seq (rd_seq), .clear (rd_ok)
    );

    sb_clear_chk #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_wr (
        .head (q_ent[wr_f][0]), .cnt (wr_cnt), .req_seq (wr_seq), .clear (wr_ok)
    );

    sb_fwd_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_fw (
        .ent      (q_ent[fw_f]),
        .cnt      (fw_cnt),
        .req_seq  (fw_seq),
        .cand_vld (fw_cand_vld),
        .cand_seq (fw_cand_seq)
    );

    assign fw_hit = fw_cand_vld && fw_exec && (fw_ready_cyc < fw_now);
endmodule

// File: rtl/sb_checks.sv
module sb_checks #(
    parameter int IDX_W = 3,
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       rd_cls,
    input logic [IDX_W-1:0] rd_idx,
    input logic [SEQ_W-1:0] rd_seq,
    input logic             rd_ok,
    input logic [1:0]       wr_cls,
    input logic [IDX_W-1:0] wr_idx,
    input logic [SEQ_W-1:0] wr_seq,
    input logic             wr_ok,
    input logic [1:0]       fw_cls,
    input logic [IDX_W-1:0] fw_idx,
    input logic [SEQ_W-1:0] fw_seq,
    input logic             fw_cand_vld,
    input logic [SEQ_W-1:0] fw_cand_seq,
    input logic             rmh_vld,
    input logic [1:0]       rmh_cls,
    input logic [IDX_W-1:0] rmh_idx,
    input logic             err_rmh_bad
);
    assert_empty_after_reset_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_ok && wr_ok && !fw_cand_vld));

    assert_no_reg_class3_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_cls == 2'd3) |-> rd_ok);

    assert_zero_reg_no_error_R3: assert property (@(posedge clk) disable iff (rst)
        (rmh_vld && rmh_cls == 2'd0 && rmh_idx == '0) |-> !err_rmh_bad);

    assert_zero_reg_no_cand_R3: assert property (@(posedge clk) disable iff (rst)
        (fw_cls == 2'd0 && fw_idx == '0) |-> !fw_cand_vld);

    assert_same_rule_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_cls == wr_cls && rd_idx == wr_idx && rd_seq == wr_seq) |-> (rd_ok == wr_ok));

    assert_cand_older_R6: assert property (@(posedge clk) disable iff (rst)
        fw_cand_vld |-> (fw_cand_seq < fw_seq));
endmodule

bind regdep_scoreboard sb_checks #(.IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_cls      (rd_cls),
    .rd_idx      (rd_idx),
    .rd_seq      (rd_seq),
    .rd_ok       (rd_ok),
    .wr_cls      (wr_cls),
    .wr_idx      (wr_idx),
    .wr_seq      (wr_seq),
    .wr_ok       (wr_ok),
    .fw_cls      (fw_cls),
    .fw_idx      (fw_idx),
    .fw_seq      (fw_seq),
    .fw_cand_vld (fw_cand_vld),
    .fw_cand_seq (fw_cand_seq),
    .rmh_vld     (rmh_vld),
    .rmh_cls     (rmh_cls),
    .rmh_idx     (rmh_idx),
    .err_rmh_bad (err_rmh_bad)
);

// File: tb/sim_regdep_scoreboard.sv
module sim_regdep_scoreboard;
    localparam int CLK_PER = 10;
    localparam int IDX_W = 3;
    localparam int DEPTH = 4;
    localparam int SEQ_W = 16;
    localparam int CYC_W = 16;
    localparam int NR = 1 << IDX_W;
    localparam int NQ = 3 * NR;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic             ins_vld, rma_vld, rmh_vld;
    logic [1:0]       ins_cls, rma_cls, rmh_cls, rd_cls, wr_cls, fw_cls;
    logic [IDX_W-1:0] ins_idx, rma_idx, rmh_idx, rd_idx, wr_idx, fw_idx;
    logic [SEQ_W-1:0] ins_seq, rma_seq, rmh_seq, rd_seq, wr_seq, fw_seq;
    logic             rd_ok, wr_ok, fw_cand_vld, fw_exec, fw_hit;
    logic [SEQ_W-1:0] fw_cand_seq;
    logic [CYC_W-1:0] fw_ready_cyc, fw_now;
    logic             err_ovf, err_rma_miss, err_rmh_bad;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int nseq = 1;

    int unsigned mq [NQ][DEPTH];
    int          mc [NQ];

    always #(CLK_PER/2) clk = ~clk;

    regdep_scoreboard #(.IDX_W(IDX_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CYC_W(CYC_W)) u0 (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int qof(input logic [1:0] c, input logic [IDX_W-1:0] i);
        if (c == 2'd3) return -1;
        return int'(c) * NR + int'(i);
    endfunction

    function automatic bit trk(input logic [1:0] c, input logic [IDX_W-1:0] i);
        return c != 2'd3 && !(c == 2'd0 && i == '0);
    endfunction

    function automatic bit m_clear(input logic [1:0] c, input logic [IDX_W-1:0] i, input int unsigned s);
        int q = qof(c, i);
        if (q < 0 || mc[q] == 0) return 1;
        return s <= mq[q][0];
    endfunction

    task automatic m_cand(input logic [1:0] c, input logic [IDX_W-1:0] i, input int unsigned s,
                          output bit v, output int unsigned cs);
        int q = qof(c, i);
        v = 0; cs = 0;
        if (q >= 0) begin
            for (int k = 0; k < mc[q]; k++) begin
                if (mq[q][k] < s) begin v = 1; cs = mq[q][k]; end
                else break;
            end
        end
    endtask

    task automatic idle();
        ins_vld = 0; rma_vld = 0; rmh_vld = 0;
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) mc[q] = 0;
    endtask

    // compare this cycle's answers against the pre-update model, then update
    task automatic do_check();
        bit ev, eh, em, eo;
        int unsigned es;
        int q;
        #1;
        chk("R4 rd_ok", rd_ok, m_clear(rd_cls, rd_idx, rd_seq));
        chk("R5 wr_ok", wr_ok, m_clear(wr_cls, wr_idx, wr_seq));
        m_cand(fw_cls, fw_idx, fw_seq, ev, es);
        chk("R6 fw_cand_vld", fw_cand_vld, ev);
        if (ev) chk("R6 fw_cand_seq", fw_cand_seq, es);
        chk("R7 fw_hit", fw_hit, ev && fw_exec && (fw_ready_cyc < fw_now));
        eh = 0; em = 0; eo = 0;
        if (rmh_vld && trk(rmh_cls, rmh_idx)) begin
            q = qof(rmh_cls, rmh_idx);
            if (mc[q] == 0 || mq[q][0] != rmh_seq) eh = 1;
            else begin
                for (int k = 0; k < DEPTH - 1; k++) mq[q][k] = mq[q][k+1];
                mc[q]--;
            end
        end
        if (rma_vld && trk(rma_cls, rma_idx)) begin
            int pos = -1;
            q = qof(rma_cls, rma_idx);
            for (int k = 0; k < mc[q]; k++) if (pos < 0 && mq[q][k] == rma_seq) pos = k;
            if (pos < 0) em = 1;
            else begin
                for (int k = pos; k < DEPTH - 1; k++) mq[q][k] = mq[q][k+1];
                mc[q]--;
            end
        end
        if (ins_vld && trk(ins_cls, ins_idx)) begin
            q = qof(ins_cls, ins_idx);
            if (mc[q] == DEPTH) eo = 1;
            else begin mq[q][mc[q]] = ins_seq; mc[q]++; end
        end
        chk("R9 err_rmh_bad", err_rmh_bad, eh);
        chk("R8 err_rma_miss", err_rma_miss, em);
        chk("R10 err_ovf", err_ovf, eo);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        model_reset();
        rst = 0;
    endtask

    task automatic op_ins(input logic [1:0] c, input logic [IDX_W-1:0] i, input int unsigned s);
        @(negedge clk); idle();
        ins_vld = 1; ins_cls = c; ins_idx = i; ins_seq = SEQ_W'(s);
        do_check();
    endtask

    task automatic set_rd(input logic [1:0] c, input logic [IDX_W-1:0] i, input int unsigned s);
        rd_cls = c; rd_idx = i; rd_seq = SEQ_W'(s);
        wr_cls = c; wr_idx = i; wr_seq = SEQ_W'(s);
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        idle();
        ins_cls = 0; ins_idx = 0; ins_seq = 0;
        rma_cls = 0; rma_idx = 0; rma_seq = 0;
        rmh_cls = 0; rmh_idx = 0; rmh_seq = 0;
        set_rd(2'd0, 3'd1, 0);
        fw_cls = 0; fw_idx = 1; fw_seq = 0; fw_exec = 0; fw_ready_cyc = 0; fw_now = 0;
        model_reset();
        apply_reset();

        // R12: empty after reset
        @(negedge clk); idle(); set_rd(2'd1, 3'd3, 0);
        fw_cls = 2'd1; fw_idx = 3'd3; fw_seq = 16'hFFFF;
        do_check();
        chk("R12 rd_ok after reset", rd_ok, 1);
        chk("R12 no cand after reset", fw_cand_vld, 0);

        // R2: program order on fp register 2
        op_ins(2'd1, 3'd2, 10);
        op_ins(2'd1, 3'd2, 20);
        op_ins(2'd1, 3'd2, 30);
        @(negedge clk); idle(); rmh_vld = 1; rmh_cls = 2'd1; rmh_idx = 3'd2; rmh_seq = 30;
        do_check();
        chk("R2 head is oldest (pop 30 rejected)", err_rmh_bad, 1);
        @(negedge clk); idle(); rmh_vld = 1; rmh_seq = 10;
        do_check();
        chk("R2 pop oldest accepted", err_rmh_bad, 0);
        @(negedge clk); idle(); set_rd(2'd1, 3'd2, 25);
        do_check();
        chk("R2 head now 20", rd_ok, 0);

        // R3: integer zero register untracked
        op_ins(2'd0, 3'd0, 40);
        @(negedge clk); idle(); set_rd(2'd0, 3'd0, 99);
        rmh_vld = 1; rmh_cls = 2'd0; rmh_idx = 3'd0; rmh_seq = 7;
        do_check();
        chk("R3 zero reg readable", rd_ok, 1);
        chk("R3 zero reg pop no error", err_rmh_bad, 0);

        // R1: class 3 ignored, classes separate
        op_ins(2'd3, 3'd1, 50);
        op_ins(2'd2, 3'd1, 60);
        @(negedge clk); idle(); set_rd(2'd3, 3'd1, 99);
        do_check();
        chk("R1 class 3 query", rd_ok, 1);
        @(negedge clk); idle(); set_rd(2'd0, 3'd1, 99);
        do_check();
        chk("R1 int 1 untouched by misc 1", rd_ok, 1);
        @(negedge clk); idle(); set_rd(2'd2, 3'd1, 99);
        do_check();
        chk("R1 misc 1 pending", rd_ok, 0);

        // R10 / R11 on integer register 5
        for (int k = 0; k < DEPTH; k++) op_ins(2'd0, 3'd5, 100 + k);
        op_ins(2'd0, 3'd5, 104);
        chk("R10 overflow flagged", err_ovf, 1);
        @(negedge clk); idle();
        rmh_vld = 1; rmh_cls = 2'd0; rmh_idx = 3'd5; rmh_seq = 100;
        ins_vld = 1; ins_cls = 2'd0; ins_idx = 3'd5; ins_seq = 105;
        do_check();
        chk("R11 pop before append, no overflow", err_ovf, 0);
        @(negedge clk); idle();
        fw_cls = 2'd0; fw_idx = 3'd5; fw_seq = 104; fw_exec = 1; fw_ready_cyc = 0; fw_now = 5;
        rma_vld = 1; rma_cls = 2'd0; rma_idx = 3'd5; rma_seq = 101;
        set_rd(2'd0, 3'd5, 102);
        do_check();
        chk("R11 query sees pre-update head", rd_ok, 0);
        chk("R6 cand below 104", fw_cand_seq, 103);
        chk("R7 hit when ready earlier", fw_hit, 1);
        @(negedge clk); idle();
        fw_ready_cyc = 5;
        do_check();
        chk("R11 head advanced after edge", rd_ok, 1);
        chk("R7 no hit when ready equals now", fw_hit, 0);
        @(negedge clk); idle();
        rma_vld = 1; rma_cls = 2'd0; rma_idx = 3'd5; rma_seq = 103;
        do_check();
        chk("R8 middle delete ok", err_rma_miss, 0);
        @(negedge clk); idle();
        fw_seq = 200; fw_ready_cyc = 0;
        rma_vld = 1; rma_seq = 999;
        do_check();
        chk("R8 missing entry flagged", err_rma_miss, 1);
        chk("R8 order kept after compaction", fw_cand_seq, 105);

        // R12: mid-run reset
        apply_reset();
        @(negedge clk); idle(); set_rd(2'd0, 3'd5, 0);
        do_check();
        chk("R12 reset empties queue", rd_ok, 1);

        // random traffic on a few registers
        nseq = 300;
        for (int n = 0; n < 4000; n++) begin
            int q;
            @(negedge clk); idle();
            if ($urandom % 10 < 4) begin
                ins_vld = 1; ins_cls = 2'($urandom % 4); ins_idx = IDX_W'($urandom % 2);
                ins_seq = SEQ_W'(nseq); nseq++;
            end
            if ($urandom % 10 < 3) begin
                rmh_vld = 1; rmh_cls = 2'($urandom % 4); rmh_idx = IDX_W'($urandom % 2);
                q = qof(rmh_cls, rmh_idx);
                rmh_seq = (q >= 0 && mc[q] > 0 && $urandom % 4 != 0) ? SEQ_W'(mq[q][0]) : SEQ_W'($urandom % nseq);
            end
            if ($urandom % 10 < 2) begin
                rma_vld = 1; rma_cls = 2'($urandom % 4); rma_idx = IDX_W'($urandom % 2);
                q = qof(rma_cls, rma_idx);
                rma_seq = (q >= 0 && mc[q] > 0 && $urandom % 4 != 0) ?
                          SEQ_W'(mq[q][$urandom % mc[q]]) : SEQ_W'($urandom % nseq);
            end
            rd_cls = 2'($urandom % 4); rd_idx = IDX_W'($urandom % 2); rd_seq = SEQ_W'(nseq - $urandom % 8);
            if ($urandom % 2 == 0) begin
                wr_cls = rd_cls; wr_idx = rd_idx; wr_seq = rd_seq;
            end else begin
                wr_cls = 2'($urandom % 4); wr_idx = IDX_W'($urandom % 2); wr_seq = SEQ_W'(nseq - $urandom % 8);
            end
            fw_cls = 2'($urandom % 4); fw_idx = IDX_W'($urandom % 2); fw_seq = SEQ_W'(nseq - $urandom % 6);
            fw_exec = 1'($urandom % 2); fw_ready_cyc = CYC_W'($urandom % 16); fw_now = CYC_W'($urandom % 16);
            do_check();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule